// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Aggregator

This block keeps the interrupt flags of an Ethernet MAC in one 32-bit status word and the matching mask in one 32-bit enable word. Transmit-side events occupy the upper half of the status word and receive-side events the lower half. The transmit and receive engines raise flags with one-cycle pulses, and software reads both words and writes them through a simple register port.

Each half holds one summary bit inside the status word. The summary bit is set when one of a fixed set of three source flags in that half is set and enabled. Each direction drives its own level interrupt line. That line is high only when the summary bit and the summary bit's own enable are both set. A soft reset input returns both words and both lines to zero.

The summary bits and the lines are registered. They follow the event or register write that changes them after one clock.

Top module: `mac_irq_agg`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), status reads 0, enable reads 0, and tx_irq and rx_irq are low.
- R2: A pulse on rx_evt[i] sets status bit i, and a pulse on tx_evt[i] sets status bit 16+i. Each bit is readable one clock later, and all other bits keep their values. Pulses on rx_evt[0] and tx_evt[0] target the summary positions and are ignored.
- R3: A register write with wr_sel=0 (status) clears every status bit written as 1 and leaves the bits written as 0 unchanged. Both summaries are then recomputed.
- R4: A register write with wr_sel=1 (enable) stores wr_data into the enable word. Both summaries are then recomputed. A read with rd_sel=1 returns the enable word, and a read with rd_sel=0 returns the status word.
- R5: The transmit summary is status bit 16. It is recomputed on any transmit event, any status write and any enable write. It becomes 1 exactly when bit 18 (transmit done), bit 21 (no transmit descriptor) or bit 25 (transmit bus error) is set with its enable bit, and 0 otherwise. Other transmit flags never contribute.
- R6: The receive summary is status bit 0. It follows the same recompute rule using bit 2 (receive good), bit 5 (no receive descriptor) and bit 9 (receive bus error).
- R7: tx_irq equals status bit 16 AND enable bit 16, and rx_irq equals status bit 0 AND enable bit 0. Each line settles one clock after the event or write that changes these bits. A set summary bit whose enable is 0 leaves the line low.
- R8: When an event pulse and a status clear-write hit the same bit in one cycle, the bit ends up set.
- R9: soft_rst high at a clock edge clears status, enable, tx_irq and rx_irq. It overrides any event or write in that same cycle.
- R10: Writing 1 to a summary bit while one of its enabled source flags is still set leaves the summary bit at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status (write-one-to-clear), 1 enable |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read select: 0 status, 1 enable |
| rd_data | output | 32 | Read data, combinational from the selected word |
| tx_evt | input | 16 | Transmit event pulses, bit i sets status bit 16+i |
| rx_evt | input | 16 | Receive event pulses, bit i sets status bit i |
| tx_irq | output | 1 | Transmit interrupt line |
| rx_irq | output | 1 | Receive interrupt line |

## Verification
An engine event and a software clear-write can land on the same status bit in the same cycle. The bench provokes this by pulsing a receive event in the same cycle as a write that clears that bit and a second bit. It then judges that the targeted bit survives while the other bit is cleared. A soft reset can also coincide with an event pulse and an enable write, and the bench checks that the soft reset leaves both words and both lines at zero.

// File: rtl/mac_irq_pkg.sv
// Package: shared widths, register select encoding and mask helper for the
// MAC interrupt aggregator. Assumes a status word split into two equal halves.
package mac_irq_pkg;

    localparam int unsigned STAT_W = 32;
    localparam int unsigned HALF_W = STAT_W / 2;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    // Builds a half-word mask with the three given bit positions set.
    function automatic logic [HALF_W-1:0] three_bit_mask(input int unsigned a,
                                                         input int unsigned b,
                                                         input int unsigned c);
        logic [HALF_W-1:0] m;
        m = '0;
        m[a] = 1'b1;
        m[b] = 1'b1;
        m[c] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irq_sum_eval.sv
// Summary evaluator: reports whether any source flag is set together with its
// enable. Assumes SRC_MASK excludes the summary bit position itself.
module irq_sum_eval #(
    parameter int unsigned     W        = 16,
    parameter logic [W-1:0]    SRC_MASK = '0
) (
    input  logic [W-1:0] sta,
    input  logic [W-1:0] en,
    output logic         any_hit
);

    // Reduce the enabled source flags to one bit.
    always_comb begin
        any_hit = |(sta & en & SRC_MASK);
    end

endmodule

// File: rtl/irq_dir_slice.sv
// Direction slice: holds one half of the status and enable words, keeps the
// half's summary bit inside the status half and drives one interrupt line.
// Assumes one write strobe class per cycle (clear or enable) from the top,
// a synchronous active-low reset and a synchronous soft reset.
module irq_dir_slice #(
    parameter int unsigned  W        = 16,
    parameter int unsigned  SUM_POS  = 0,
    parameter logic [W-1:0] SRC_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [W-1:0] evt,
    input  logic         clr_we,
    input  logic         en_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] sta_q,
    output logic [W-1:0] en_q,
    output logic         irq_q
);

    localparam logic [W-1:0] SUM_BIT = W'(1) << SUM_POS;

    logic [W-1:0] evt_m;
    logic [W-1:0] clr_v;
    logic [W-1:0] sta_base;
    logic [W-1:0] sta_n;
    logic [W-1:0] en_n;
    logic         recompute;
    logic         hit;
    logic         sum_n;
    logic         irq_n;

    // Apply software clears first, then hardware sets, so a set wins.
    always_comb begin
        evt_m     = evt & ~SUM_BIT;
        clr_v     = clr_we ? wdata : '0;
        sta_base  = (sta_q & ~clr_v) | evt_m;
        en_n      = en_we ? wdata : en_q;
        recompute = clr_we | en_we | (|evt_m);
    end

    irq_sum_eval #(
        .W        (W),
        .SRC_MASK (SRC_MASK)
    ) u_eval (
        .sta     (sta_base),
        .en      (en_n),
        .any_hit (hit)
    );

    // Choose the new summary bit and the line level from next-state values.
    always_comb begin
        sum_n          = recompute ? hit : sta_q[SUM_POS];
        sta_n          = sta_base;
        sta_n[SUM_POS] = sum_n;
        irq_n          = sum_n & en_n[SUM_POS];
    end

    // Register status half, enable half and the interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            sta_q <= '0;
            en_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            sta_q <= sta_n;
            en_q  <= en_n;
            irq_q <= irq_n;
        end
    end

endmodule

// File: rtl/mac_irq_agg.sv
// Top: MAC interrupt status aggregator. Receive events live in the low half
// of the status word and transmit events in the high half. One slice per
// direction is generated. Assumes the bit position parameters place each
// direction's summary and sources inside its own half.
module mac_irq_agg
    import mac_irq_pkg::*;
#(
    parameter int unsigned RX_SUM_BIT    = 0,
    parameter int unsigned RX_GOOD_BIT   = 2,
    parameter int unsigned RX_NODESC_BIT = 5,
    parameter int unsigned RX_BUSERR_BIT = 9,
    parameter int unsigned TX_SUM_BIT    = 16,
    parameter int unsigned TX_DONE_BIT   = 18,
    parameter int unsigned TX_NODESC_BIT = 21,
    parameter int unsigned TX_BUSERR_BIT = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [STAT_W-1:0] rd_data,
    input  logic [HALF_W-1:0] tx_evt,
    input  logic [HALF_W-1:0] rx_evt,
    output logic              tx_irq,
    output logic              rx_irq
);

    localparam int unsigned NUM_DIR = 2;

    logic [STAT_W-1:0]  status_w;
    logic [STAT_W-1:0]  enable_w;
    logic [NUM_DIR-1:0] irq_w;
    logic               clr_we;
    logic               en_we;

    // Decode the write strobe into a clear-write or an enable-write.
    always_comb begin
        clr_we = wr_en && (reg_sel_e'(wr_sel) == SEL_STATUS);
        en_we  = wr_en && (reg_sel_e'(wr_sel) == SEL_ENABLE);
    end

    // One slice per direction: index 0 receive, index 1 transmit.
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        localparam int unsigned BASE  = d * HALF_W;
        localparam int unsigned SUM_L = ((d == 0) ? RX_SUM_BIT : TX_SUM_BIT) - BASE;
        localparam logic [HALF_W-1:0] SRC_L = (d == 0) ?
            three_bit_mask(RX_GOOD_BIT - BASE, RX_NODESC_BIT - BASE, RX_BUSERR_BIT - BASE) :
            three_bit_mask(TX_DONE_BIT - BASE, TX_NODESC_BIT - BASE, TX_BUSERR_BIT - BASE);

        logic [HALF_W-1:0] evt_d;

        // Route the matching engine's pulses into this slice.
        always_comb begin
            evt_d = (d == 0) ? rx_evt : tx_evt;
        end

        irq_dir_slice #(
            .W        (HALF_W),
            .SUM_POS  (SUM_L),
            .SRC_MASK (SRC_L)
        ) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .evt      (evt_d),
            .clr_we   (clr_we),
            .en_we    (en_we),
            .wdata    (wr_data[BASE +: HALF_W]),
            .sta_q    (status_w[BASE +: HALF_W]),
            .en_q     (enable_w[BASE +: HALF_W]),
            .irq_q    (irq_w[d])
        );
    end

    // Read mux and interrupt line outputs.
    always_comb begin
        rd_data = (reg_sel_e'(rd_sel) == SEL_ENABLE) ? enable_w : status_w;
        rx_irq  = irq_w[0];
        tx_irq  = irq_w[1];
    end

endmodule

// File: rtl/mac_irq_chk.sv
// Checker for the MAC interrupt aggregator, bound to the top. Relates the
// registered words, the event pulses and the interrupt lines over time.
module mac_irq_chk
    import mac_irq_pkg::*;
#(
    parameter int unsigned RX_SUM_BIT    = 0,
    parameter int unsigned RX_GOOD_BIT   = 2,
    parameter int unsigned RX_NODESC_BIT = 5,
    parameter int unsigned RX_BUSERR_BIT = 9,
    parameter int unsigned TX_SUM_BIT    = 16,
    parameter int unsigned TX_DONE_BIT   = 18,
    parameter int unsigned TX_NODESC_BIT = 21,
    parameter int unsigned TX_BUSERR_BIT = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [STAT_W-1:0] wr_data,
    input logic [HALF_W-1:0] tx_evt,
    input logic [HALF_W-1:0] rx_evt,
    input logic [STAT_W-1:0] status,
    input logic [STAT_W-1:0] enable,
    input logic              tx_irq,
    input logic              rx_irq
);

    localparam logic [STAT_W-1:0] ONE = STAT_W'(1);
    localparam logic [STAT_W-1:0] TX_SRC = (ONE << TX_DONE_BIT) | (ONE << TX_NODESC_BIT) |
                                           (ONE << TX_BUSERR_BIT);
    localparam logic [STAT_W-1:0] RX_SRC = (ONE << RX_GOOD_BIT) | (ONE << RX_NODESC_BIT) |
                                           (ONE << RX_BUSERR_BIT);
    localparam logic [STAT_W-1:0] SUM_MASK = (ONE << TX_SUM_BIT) | (ONE << RX_SUM_BIT);

    logic [STAT_W-1:0] evt_m;

    // Event pulses placed in the status word, summary positions removed.
    always_comb begin
        evt_m = {tx_evt, rx_evt} & ~SUM_MASK;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && enable == '0 && !tx_irq && !rx_irq));

    // R4
    enable_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && !soft_rst) |=> (enable == $past(wr_data)));

    // R5
    tx_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[TX_SUM_BIT] == (|(status & enable & TX_SRC)));

    // R6
    rx_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[RX_SUM_BIT] == (|(status & enable & RX_SRC)));

    // R7
    tx_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq == (status[TX_SUM_BIT] & enable[TX_SUM_BIT]));

    // R7
    rx_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq == (status[RX_SUM_BIT] & enable[RX_SUM_BIT]));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> ((status & $past(evt_m)) == $past(evt_m)));

    // R9
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (status == '0 && enable == '0 && !tx_irq && !rx_irq));

endmodule

bind mac_irq_agg mac_irq_chk #(
    .RX_SUM_BIT    (RX_SUM_BIT),
    .RX_GOOD_BIT   (RX_GOOD_BIT),
    .RX_NODESC_BIT (RX_NODESC_BIT),
    .RX_BUSERR_BIT (RX_BUSERR_BIT),
    .TX_SUM_BIT    (TX_SUM_BIT),
    .TX_DONE_BIT   (TX_DONE_BIT),
    .TX_NODESC_BIT (TX_NODESC_BIT),
    .TX_BUSERR_BIT (TX_BUSERR_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .tx_evt   (tx_evt),
    .rx_evt   (rx_evt),
    .status   (status_w),
    .enable   (enable_w),
    .tx_irq   (tx_irq),
    .rx_irq   (rx_irq)
);

// File: tb/tb_mac_irq_agg.sv
// Directed bench for the MAC interrupt aggregator: one task per scenario.
// Inputs change at falling edges; results are sampled at the next falling edge.
module tb_mac_irq_agg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic [15:0] tx_evt = '0;
    logic [15:0] rx_evt = '0;
    logic        tx_irq;
    logic        rx_irq;

    int n_chk = 0;
    int n_bad = 0;

    mac_irq_agg dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .tx_evt   (tx_evt),
        .rx_evt   (rx_evt),
        .tx_irq   (tx_irq),
        .rx_irq   (rx_irq)
    );

    // 100 MHz clock.
    always #5 clk = ~clk;

    // Compare one value and report a mismatch.
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic [15:0] tx, input logic [15:0] rx);
        tx_evt = tx; rx_evt = rx;
        @(negedge clk);
        tx_evt = '0; rx_evt = '0;
    endtask

    task automatic clear_all();
        reg_write(1'b0, 32'hFFFF_FFFF);
        reg_write(1'b1, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        read_reg(1'b0, v); check("R1 status", v, 32'h0);
        read_reg(1'b1, v); check("R1 enable", v, 32'h0);
        check("R1 lines", {30'd0, tx_irq, rx_irq}, 32'h0);
    endtask

    task automatic t_events();
        logic [31:0] v;
        pulse(16'h0000, 16'h0084);
        read_reg(1'b0, v); check("R2 rx set", v, 32'h0000_0084);
        pulse(16'h0001, 16'h0001);
        read_reg(1'b0, v); check("R2 summary pulses ignored", v, 32'h0000_0084);
        pulse(16'h0008, 16'h0000);
        read_reg(1'b0, v); check("R2 tx set", v, 32'h0008_0084);
        reg_write(1'b0, 32'h0000_0004);
        read_reg(1'b0, v); check("R3 partial clear", v, 32'h0008_0080);
        reg_write(1'b0, 32'hFFFF_FFFF);
        read_reg(1'b0, v); check("R3 full clear", v, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        reg_write(1'b1, 32'hA5A5_5A5A);
        read_reg(1'b1, v); check("R4 enable store", v, 32'hA5A5_5A5A);
        reg_write(1'b1, 32'h0);
        read_reg(1'b1, v); check("R4 enable zero", v, 32'h0);
    endtask

    task automatic t_tx_summary();
        logic [31:0] v;
        reg_write(1'b1, 32'h0004_0000);
        pulse(16'h0004, 16'h0000);
        read_reg(1'b0, v); check("R5 summary set", v, 32'h0005_0000);
        check("R7 line needs own enable", {31'd0, tx_irq}, 32'h0);
        reg_write(1'b1, 32'h0005_0000);
        check("R7 tx line one clock after enable", {31'd0, tx_irq}, 32'h1);
        check("R7 rx line idle", {31'd0, rx_irq}, 32'h0);
        clear_all();
        reg_write(1'b1, 32'hFFFF_FFFF);
        pulse(16'h0010, 16'h0000);
        read_reg(1'b0, v); check("R5 non-source flag", v, 32'h0010_0000);
        check("R5 line stays low", {31'd0, tx_irq}, 32'h0);
        pulse(16'h0004, 16'h0000);
        check("R7 tx line after event", {31'd0, tx_irq}, 32'h1);
        reg_write(1'b0, 32'h0001_0000);
        read_reg(1'b0, v); check("R10 summary re-asserts", v, 32'h0015_0000);
        reg_write(1'b1, 32'h0001_0000);
        read_reg(1'b0, v); check("R5 source disabled", v, 32'h0014_0000);
        check("R5 line drops", {31'd0, tx_irq}, 32'h0);
        clear_all();
    endtask

    task automatic t_rx_summary();
        logic [31:0] v;
        reg_write(1'b1, 32'h0000_0201);
        pulse(16'h0000, 16'h0200);
        read_reg(1'b0, v); check("R6 rx summary set", v, 32'h0000_0201);
        check("R7 rx line one clock after event", {31'd0, rx_irq}, 32'h1);
        check("R7 tx line idle", {31'd0, tx_irq}, 32'h0);
        reg_write(1'b0, 32'h0000_0200);
        read_reg(1'b0, v); check("R6 rx summary cleared", v, 32'h0);
        check("R6 rx line drops", {31'd0, rx_irq}, 32'h0);
        clear_all();
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        pulse(16'h0000, 16'h0024);
        read_reg(1'b0, v); check("R8 setup", v, 32'h0000_0024);
        rx_evt = 16'h0020;
        reg_write(1'b0, 32'h0000_0024);
        rx_evt = '0;
        read_reg(1'b0, v); check("R8 set beats clear", v, 32'h0000_0020);
        clear_all();
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        reg_write(1'b1, 32'hFFFF_FFFF);
        pulse(16'h0000, 16'h0200);
        check("R9 setup rx line", {31'd0, rx_irq}, 32'h1);
        soft_rst = 1'b1;
        tx_evt = 16'h0004;
        reg_write(1'b1, 32'hFFFF_FFFF);
        soft_rst = 1'b0;
        tx_evt = '0;
        read_reg(1'b0, v); check("R9 status cleared", v, 32'h0);
        read_reg(1'b1, v); check("R9 enable cleared", v, 32'h0);
        check("R9 lines low", {30'd0, tx_irq, rx_irq}, 32'h0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Main sequence.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_events();
        t_enable();
        t_tx_summary();
        t_rx_summary();
        t_set_wins();
        t_soft_reset();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule